// File: doc/BRIEF.md
# Interleaved Multiphase Gate Sequencer

This block drives the switches of up to three parallel dual-phase switched-capacitor converter units. It runs from the output of an external variable-frequency oscillator. Twelve clock ticks make one switching period, so the period follows the oscillator and sets the output regulation. Each unit owns two flying capacitors. One capacitor charges from the input during one half of the period while the other discharges into the load, and the roles swap at mid-period. Every charging gate has a discharging gate that is its exact complement.

Two load comparator bits choose how many units switch: one, two or three. The active units are spread evenly over the period, so their charging edges are a fixed number of ticks apart. That spacing depends on the live count: 6 ticks for one unit, 3 for two, and 2 for three. A unit that is not switching keeps both charging gates open and both discharging gates closed. Its capacitors then sit across the output and add to the output capacitance. The count is re-read only when a period wraps.

The controller is a two-state machine. `ST_PARK` is entered on reset and keeps every unit idle. `ST_RUN` is normal interleaved operation. There is one transition, PARK_TO_RUN, and it fires on the last tick of the first full period after reset is released. Reset is the only way back to `ST_PARK`. In `ST_RUN`, the period-boundary event COUNT_LOAD copies the synchronized load decode into the active-unit count.

Top module: `sc_interleave_seq`

## Requirements
- R1: The internal tick runs 0 through 11 and then wraps to 0, so the drive pattern repeats every 12 clock cycles.
- R2: Every charging gate of an active unit is high for 6 consecutive ticks of each period.
- R3: Within an active unit, exactly one of the two charging gates is high on every tick, and gate B rises 6 ticks after gate A.
- R4: With n active units, charging gate A of unit k (k = 0..n-1) is high on ticks k*12/(2n) through k*12/(2n)+5. This gives offsets 0 for n=1; 0 and 3 for n=2; and 0, 2 and 4 for n=3.
- R5: The load code {load_hi, load_lo} decodes as 00 to 1 active unit, 01 or 10 to 2 units, and 11 to 3 units.
- R6: Each discharging gate is always the logical inverse of the charging gate with the same unit and letter.
- R7: A unit whose index is at or above the active count holds both charging gates low and both discharging gates high.
- R8: The comparator bits pass through two synchronizing flops. A new count takes effect only at tick 0 of a period, so a load change made mid-period leaves the rest of that period unchanged.
- R9: While reset is asserted and during the first 12 ticks after it is released, every unit is idle and the tick counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_lo | input | 1 | Comparator: load above low threshold (asynchronous) |
| load_hi | input | 1 | Comparator: load above high threshold (asynchronous) |
| chg_a | output | NUM_UNITS | Charging gate of capacitor A, one bit per unit |
| chg_b | output | NUM_UNITS | Charging gate of capacitor B, one bit per unit |
| dis_a | output | NUM_UNITS | Discharging gate of capacitor A, inverse of chg_a |
| dis_b | output | NUM_UNITS | Discharging gate of capacitor B, inverse of chg_b |

## Verification
The bench steps through every ordered pair of the four load codes. Each new code is applied mid-period, and all gates of all units are compared on every tick against offsets computed from the active count. A design that applied the new count at once would shift the unit offsets before the period ended. A design that decoded 01 and 10 differently would put a unit in the wrong slot or leave it idle. A design with a wrong offset divisor would make two units charge together. Reset is asserted both at start-up and in the middle of a run, to show that every unit parks with its discharging switches closed and stays parked for one full period before switching resumes.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

    typedef enum logic {
        ST_PARK = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Position of a tick inside the charging cycle of capacitor A of a unit,
    // measured from that unit's staggered start.
    function automatic int phase_pos(int tick, int unit, int n_act, int ticks);
        int n_safe;
        int offs;
        n_safe = (n_act < 1) ? 1 : n_act;
        offs   = (unit * ticks) / (2 * n_safe);
        return (tick + ticks - offs) % ticks;
    endfunction

endpackage

// File: rtl/sc_load_sync.sv
module sc_load_sync #(
    parameter int NUM_UNITS = 3,
    localparam int NW = $clog2(NUM_UNITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_lo,
    input  logic          load_hi,
    output logic [NW-1:0] n_req
);
    logic [1:0] meta_q;
    logic [1:0] sync_q;
    int         sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= {load_hi, load_lo};
            sync_q <= meta_q;
        end
    end

    // Thermometer-style decode: one unit plus one per comparator that trips.
    always_comb begin
        sum   = 1 + int'(sync_q[0]) + int'(sync_q[1]);
        n_req = NW'((sum > NUM_UNITS) ? NUM_UNITS : sum);
    end

endmodule

// File: rtl/sc_tick_counter.sv
module sc_tick_counter #(
    parameter int TICKS = 12,
    localparam int TW = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick_q,
    output logic [TW-1:0] tick_nxt,
    output logic          tick_last
);
    always_comb begin
        tick_last = (tick_q == TW'(TICKS - 1));
        tick_nxt  = tick_last ? '0 : tick_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_nxt;
    end

    // R1: the period closes after exactly TICKS cycles
    p_period_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == TW'(TICKS - 1)) |=> (tick_q == '0));

endmodule

// File: rtl/sc_unit_drive.sv
module sc_unit_drive #(
    parameter int UNIT  = 0,
    parameter int TICKS = 12,
    parameter int NW    = 2,
    localparam int TW = $clog2(TICKS),
    localparam int HALF = TICKS / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tick_nxt,
    input  logic [NW-1:0] n_nxt,
    input  logic          run_nxt,
    output logic          chg_a,
    output logic          chg_b
);
    logic active_nxt;
    logic active_q;
    logic a_nxt;
    int   rel;

    always_comb begin
        active_nxt = run_nxt && (UNIT < int'(n_nxt));
        rel        = sc_seq_pkg::phase_pos(int'(tick_nxt), UNIT, int'(n_nxt), TICKS);
        a_nxt      = (rel < HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            chg_a    <= 1'b0;
            chg_b    <= 1'b0;
        end else begin
            active_q <= active_nxt;
            chg_a    <= active_nxt && a_nxt;
            chg_b    <= active_nxt && !a_nxt;
        end
    end

    // R3: an active unit always charges exactly one of its two capacitors
    p_one_charging_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (chg_a ^ chg_b));

endmodule

// File: rtl/sc_interleave_seq.sv
module sc_interleave_seq #(
    parameter int NUM_UNITS = 3,
    parameter int TICKS     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_lo,
    input  logic                 load_hi,
    output logic [NUM_UNITS-1:0] chg_a,
    output logic [NUM_UNITS-1:0] chg_b,
    output logic [NUM_UNITS-1:0] dis_a,
    output logic [NUM_UNITS-1:0] dis_b
);
    import sc_seq_pkg::*;

    localparam int TW = $clog2(TICKS);
    localparam int NW = $clog2(NUM_UNITS + 1);

    logic [TW-1:0] tick_q;
    logic [TW-1:0] tick_nxt;
    logic          tick_last;
    logic [NW-1:0] n_req;
    logic [NW-1:0] n_q;
    logic [NW-1:0] n_nxt;
    seq_state_e    state_q;
    seq_state_e    state_nxt;
    logic          run_nxt;

    sc_tick_counter #(.TICKS(TICKS)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_q    (tick_q),
        .tick_nxt  (tick_nxt),
        .tick_last (tick_last)
    );

    sc_load_sync #(.NUM_UNITS(NUM_UNITS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .n_req   (n_req)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            n_q     <= NW'(1);
        end else begin
            state_q <= state_nxt;
            n_q     <= n_nxt;
        end
    end

    // Next state and count: PARK_TO_RUN and COUNT_LOAD both occur on the last tick
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_PARK: if (tick_last) state_nxt = ST_RUN;
            ST_RUN:  state_nxt = ST_RUN;
        endcase
        n_nxt   = tick_last ? n_req : n_q;
        run_nxt = (state_nxt == ST_RUN);
    end

    // Output drive: one registered charging bit per gate, complement discharges
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        sc_unit_drive #(.UNIT(u), .TICKS(TICKS), .NW(NW)) u_drv (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_nxt (tick_nxt),
            .n_nxt    (n_nxt),
            .run_nxt  (run_nxt),
            .chg_a    (chg_a[u]),
            .chg_b    (chg_b[u])
        );

        // R7: units beyond the live count never charge
        p_idle_unit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (u >= int'(n_q)) |-> (!chg_a[u] && !chg_b[u]));
    end

    assign dis_a = ~chg_a;
    assign dis_b = ~chg_b;

    // R8: the active count only changes as a new period begins
    p_count_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q != $past(n_q)) |-> (tick_q == '0));

    // R9: while parked no charging gate is driven
    p_parked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK) |-> (chg_a == '0 && chg_b == '0));

endmodule

// File: tb/tb_sc_interleave_seq.sv
`timescale 1ns/1ps
module tb_sc_interleave_seq;
    localparam int NU = 3;
    localparam int TK = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_lo = 1'b0;
    logic load_hi = 1'b0;
    logic [NU-1:0] chg_a, chg_b, dis_a, dis_b;

    int tests = 0;
    int fails = 0;
    int c = 0;
    int n_cur = 1;
    int n_pend = 1;
    bit running = 1'b0;

    always #2.5 clk = ~clk;

    sc_interleave_seq #(.NUM_UNITS(NU), .TICKS(TK)) dut (
        .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .load_hi(load_hi),
        .chg_a(chg_a), .chg_b(chg_b), .dis_a(dis_a), .dis_b(dis_b)
    );

    // R5: {hi,lo} 00 -> 1, 01/10 -> 2, 11 -> 3
    function automatic int decode(int code);
        return 1 + (code & 1) + ((code >> 1) & 1);
    endfunction

    // R4: gate A of unit u is high on ticks [offset, offset+5]; offset < 6 always
    function automatic bit exp_a(int u, int tick, int n, bit run);
        int offs;
        if (!run || u >= n) return 1'b0;
        offs = (u * TK) / (2 * n);
        return (tick >= offs) && (tick < offs + TK / 2);
    endfunction

    // R3/R7: gate B is the other half for active units, low for idle units
    function automatic bit exp_b(int u, int tick, int n, bit run);
        if (!run || u >= n) return 1'b0;
        return !exp_a(u, tick, n, run);
    endfunction

    task automatic check_outputs(string phase);
        int tick;
        tick = c % TK;
        for (int u = 0; u < NU; u++) begin
            logic [3:0] got;
            logic [3:0] exp;
            bit ea, eb;
            ea  = exp_a(u, tick, n_cur, running);
            eb  = exp_b(u, tick, n_cur, running);
            got = {chg_a[u], chg_b[u], dis_a[u], dis_b[u]};
            exp = {ea, eb, !ea, !eb};
            tests++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s unit %0d tick %0d n %0d: got %b expected %b",
                         (!running) ? "R9" : ((u >= n_cur) ? "R7" : "R4"),
                         u, tick, n_cur, got, exp);
            end
        end
        // R6: discharging gates are complements of charging gates
        tests++;
        if ((dis_a !== ~chg_a) || (dis_b !== ~chg_b)) begin
            fails++;
            $display("FAIL R6 %s: dis %b/%b expected %b/%b", phase, dis_a, dis_b, ~chg_a, ~chg_b);
        end
    endtask

    task automatic step();
        @(posedge clk);
        c++;
        // R1/R8: a new period starts every 12 cycles and picks up the pending count
        if (c % TK == 0) begin
            running = 1'b1;
            n_cur   = n_pend;
        end
        @(negedge clk);
        check_outputs("run");
    endtask

    // One period; optionally change the load code at tick 3 (R8 mid-period change)
    task automatic run_period(int code, bit change);
        int  cnt_a0;
        bit  was_running;
        cnt_a0      = 0;
        was_running = running;
        for (int i = 0; i < TK; i++) begin
            step();
            if (chg_a[0]) cnt_a0++;
            if (change && (c % TK == 3)) begin
                {load_hi, load_lo} = 2'(code);
                n_pend = decode(code);
            end
        end
        // R2: unit 0 gate A high for 6 ticks per period
        if (was_running) begin
            tests++;
            if (cnt_a0 != TK / 2) begin
                fails++;
                $display("FAIL R2 unit 0 high ticks: got %0d expected %0d", cnt_a0, TK / 2);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            tests++;
            if (chg_a !== '0 || chg_b !== '0 || dis_a !== '1 || dis_b !== '1) begin
                fails++;
                $display("FAIL R9 in reset: got %b %b %b %b expected all idle",
                         chg_a, chg_b, dis_a, dis_b);
            end
        end
        rst_n   = 1'b1;
        c       = 0;
        running = 1'b0;
        n_cur   = 1;
        n_pend  = decode(int'({load_hi, load_lo}));
        check_outputs("release");
    endtask

    initial begin
        do_reset();
        run_period(0, 1'b0);     // R9: first period parked
        // Sweep every ordered pair of load codes (R4, R5, R7, R8)
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                run_period(a, 1'b1);
                run_period(a, 1'b0);
                run_period(b, 1'b1);
                run_period(b, 1'b0);
            end
        end
        // R9: reset in the middle of heavy-load operation
        run_period(3, 1'b1);
        do_reset();
        for (int i = 0; i < 3; i++) run_period(3, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule